// File: doc/BRIEF.md
# Escape-Byte Inserter and Word Packer

This block sits at the tail of a header-writing pipeline. It takes one byte per cycle from an upstream bit packer over a valid/ready handshake. It can insert escape bytes so that a run of zero bytes is never followed directly by a byte that could be read as a start-code prefix. It then gathers the resulting bytes into wide words, most significant byte first, and hands each word to a word-wide sink over a second valid/ready handshake.

A level input, `esc_en`, turns escaping on or off. Any change of its value clears the zero-run history. A `flush` pulse closes out a partly filled word, padding it with zero bytes. A free-running counter reports how many bits have left the block so far, and inserted escape bytes count toward it. Escape insertion costs one cycle: the input is held off while the escape byte goes out, and the data byte follows in the next cycle.

Top module: `escape_word_packer`

## Requirements
- R1: With `esc_en` high and the last two bytes counted as zeros, an incoming byte of 0x00, 0x01 or 0x03 is preceded in the output by one extra byte 0x03. Any other value, for example 0x02 or 0x04, passes with no escape.
- R2: An inserted escape byte clears the zero-run count. The data byte that follows it then starts a new count of one if it is 0x00, so five 0x00 inputs produce 00 00 03 00 00 03 00.
- R3: A change of `esc_en` from the value it held in the previous cycle clears the zero-run count at once. Holding the same value through idle cycles keeps the count.
- R4: With `esc_en` low, bytes pass unchanged and no escape is ever inserted.
- R5: Output bytes fill a word from the top lane down: the first byte goes to bits 31:24, then 23:16, 15:8 and 7:0 (for the default width of 4 bytes).
- R6: A word is presented on `out_valid` in the cycle after its last byte is accepted. The next byte then opens a fresh word whose other lanes are zero.
- R7: `flush` presents a partly filled word with its unused low lanes as zero and restarts at the top lane. A flush with no bytes pending presents nothing. A flush that arrives while the output is stalled is remembered until it can act.
- R8: `bit_count` grows by exactly 8 for every byte that enters the output stream, escape bytes included, one cycle after that byte.
- R9: After reset, `out_valid` is 0, `bit_count` is 0, the lane position is the top lane and the zero-run count is clear.
- R10: `in_ready` is low for exactly one cycle when an escape byte is sent in place of the held input, provided the output is not stalled.
- R11: While `out_valid` is high and `out_ready` is low, `out_word` holds its value, `in_ready` is low, and no byte is lost or reordered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| esc_en | input | 1 | Escaping mode; a change clears the zero-run count |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte is taken this cycle |
| flush | input | 1 | Close out the partly filled word |
| out_valid | output | 1 | Output word is valid |
| out_word | output | WORD_BYTES*8 | Packed output word, first byte in the top lane |
| out_ready | input | 1 | Sink takes the output word |
| bit_count | output | CNT_W | Bits emitted so far, escapes included |

## Verification
Four things are checked on every cycle: the output word stays stable under back-pressure, intake stops while the output is stalled, the bit counter only ever steps by 0 or 8, and any input refusal with a free output is caused by an escape candidate and lasts one cycle. Whether the right bytes come out in the right lanes cannot be shown cycle by cycle. The zero-run history across escapes, mode toggles and idle gaps, the zero padding of flushed words, and a flush held across a stall are shown only by the bench scenarios against its reference model.

// File: rtl/ewp_pkg.sv
package ewp_pkg;

  localparam int BYTE_BITS = 8;

  typedef logic [BYTE_BITS-1:0] byte_t;

  // escape value inserted ahead of a guarded byte
  localparam byte_t ESC_BYTE = 8'h03;

  // zero-run history, saturating at two
  typedef enum logic [1:0] {
    ZR_NONE = 2'd0,
    ZR_ONE  = 2'd1,
    ZR_TWO  = 2'd2
  } zrun_e;

  // bytes that may not follow two zeros unescaped
  function automatic logic is_guard_byte(input byte_t b);
    return (b == 8'h00) || (b == 8'h01) || (b == 8'h03);
  endfunction

  function automatic zrun_e zrun_step(input zrun_e z);
    case (z)
      ZR_NONE: return ZR_ONE;
      default: return ZR_TWO;
    endcase
  endfunction

endpackage

// File: rtl/ewp_escape_stage.sv
module ewp_escape_stage
  import ewp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  esc_en,
  input  logic  in_valid,
  input  byte_t in_data,
  input  logic  pack_ready,
  output logic  in_ready,
  output logic  byte_fire,
  output byte_t byte_out
);

  logic  mode_q;
  zrun_e zrun_q;
  zrun_e zrun_eff;
  zrun_e zrun_nxt;
  logic  esc_sent_q;
  logic  esc_need;

  // a mode change takes effect in the same cycle as a cleared history
  assign zrun_eff = (esc_en != mode_q) ? ZR_NONE : zrun_q;

  assign esc_need = esc_en && in_valid && !esc_sent_q &&
                    (zrun_eff == ZR_TWO) && is_guard_byte(in_data);

  assign byte_fire = in_valid && pack_ready;
  assign in_ready  = pack_ready && !esc_need;
  assign byte_out  = esc_need ? ESC_BYTE : in_data;

  always_comb begin
    zrun_nxt = zrun_eff;
    if (byte_fire) begin
      if (esc_need) begin
        zrun_nxt = ZR_NONE;
      end else if (esc_en) begin
        zrun_nxt = (in_data == 8'h00) ? zrun_step(zrun_eff) : ZR_NONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= 1'b0;
      zrun_q     <= ZR_NONE;
      esc_sent_q <= 1'b0;
    end else begin
      mode_q <= esc_en;
      zrun_q <= zrun_nxt;
      if (byte_fire) begin
        esc_sent_q <= esc_need;
      end
    end
  end

endmodule

// File: rtl/ewp_word_packer.sv
module ewp_word_packer
  import ewp_pkg::*;
#(
  parameter int WORD_BYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          byte_fire,
  input  byte_t                         byte_in,
  input  logic                          flush,
  input  logic                          out_ready,
  output logic                          pack_ready,
  output logic                          out_valid,
  output logic [WORD_BYTES*BYTE_BITS-1:0] out_word
);

  localparam int POS_W = (WORD_BYTES > 2) ? $clog2(WORD_BYTES) : 1;
  localparam logic [POS_W:0] FULL_POS = (POS_W+1)'(WORD_BYTES);

  logic [WORD_BYTES-1:0][BYTE_BITS-1:0] acc_q;
  logic [WORD_BYTES-1:0][BYTE_BITS-1:0] lane_nxt;
  logic [POS_W-1:0] pos_q;
  logic [POS_W:0]   pos_sum;
  logic             flush_pend_q;
  logic             flush_now;
  logic             emit;
  logic             out_valid_q;
  logic [WORD_BYTES*BYTE_BITS-1:0] out_word_q;

  assign pack_ready = !out_valid_q || out_ready;

  // lane WORD_BYTES-1 is the most significant one and is filled first
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    localparam logic [POS_W-1:0] SLOT = POS_W'(WORD_BYTES - 1 - g);
    assign lane_nxt[g] = (byte_fire && (pos_q == SLOT)) ? byte_in :
                         (pos_q == '0)                  ? '0      :
                                                          acc_q[g];
  end

  assign pos_sum   = {1'b0, pos_q} + (POS_W+1)'(byte_fire);
  assign flush_now = flush || flush_pend_q;
  assign emit      = (pos_sum == FULL_POS) || (flush_now && (pos_sum != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q        <= '0;
      pos_q        <= '0;
      flush_pend_q <= 1'b0;
      out_valid_q  <= 1'b0;
    end else if (pack_ready) begin
      acc_q        <= lane_nxt;
      out_valid_q  <= emit;
      flush_pend_q <= 1'b0;
      pos_q        <= emit ? '0 : pos_sum[POS_W-1:0];
    end else begin
      flush_pend_q <= flush_now;
    end
  end

  // data register without reset
  always_ff @(posedge clk) begin
    if (pack_ready && emit) begin
      out_word_q <= lane_nxt;
    end
  end

  assign out_valid = out_valid_q;
  assign out_word  = out_word_q;

endmodule

// File: rtl/ewp_bit_counter.sv
module ewp_bit_counter
  import ewp_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_fire,
  output logic [CNT_W-1:0] bit_count
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(BYTE_BITS);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (byte_fire) begin
      count_q <= count_q + STEP;
    end
  end

  assign bit_count = count_q;

endmodule

// File: rtl/escape_word_packer.sv
module escape_word_packer
  import ewp_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    esc_en,
  input  logic                    in_valid,
  input  logic [7:0]              in_data,
  output logic                    in_ready,
  input  logic                    flush,
  output logic                    out_valid,
  output logic [WORD_BYTES*8-1:0] out_word,
  input  logic                    out_ready,
  output logic [CNT_W-1:0]        bit_count
);

  logic  pack_ready;
  logic  byte_fire;
  byte_t byte_out;

  ewp_escape_stage u_escape (
    .clk        (clk),
    .rst        (rst),
    .esc_en     (esc_en),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .pack_ready (pack_ready),
    .in_ready   (in_ready),
    .byte_fire  (byte_fire),
    .byte_out   (byte_out)
  );

  ewp_word_packer #(
    .WORD_BYTES (WORD_BYTES)
  ) u_pack (
    .clk        (clk),
    .rst        (rst),
    .byte_fire  (byte_fire),
    .byte_in    (byte_out),
    .flush      (flush),
    .out_ready  (out_ready),
    .pack_ready (pack_ready),
    .out_valid  (out_valid),
    .out_word   (out_word)
  );

  ewp_bit_counter #(
    .CNT_W (CNT_W)
  ) u_bits (
    .clk       (clk),
    .rst       (rst),
    .byte_fire (byte_fire),
    .bit_count (bit_count)
  );

endmodule

// File: rtl/ewp_checker.sv
module ewp_checker #(
  parameter int WORD_BYTES = 4,
  parameter int CNT_W      = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    esc_en,
  input logic                    in_valid,
  input logic [7:0]              in_data,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic [WORD_BYTES*8-1:0] out_word,
  input logic                    out_ready,
  input logic [CNT_W-1:0]        bit_count
);

  localparam logic [CNT_W-1:0] STEP = CNT_W'(8);

  logic rst_d;

  // R11: a stalled word stays put
  p_hold_word_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  // R11: no intake while the output register is blocked
  p_stall_intake_r11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R8: the bit counter moves by one byte at most per cycle
  p_bits_step_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((bit_count == $past(bit_count)) ||
              (bit_count == $past(bit_count) + STEP)));

  // R1: with a free output, a refused byte is always an escape candidate
  p_refuse_cause_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready && (!out_valid || out_ready)) |->
      (esc_en && ((in_data == 8'h00) || (in_data == 8'h01) || (in_data == 8'h03))));

  // R10: the escape refusal lasts a single cycle
  p_one_cycle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready && (!out_valid || out_ready)) |=>
      (!in_valid || in_ready || (out_valid && !out_ready)));

  // R9: state leaving reset
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d && !rst) begin
      p_reset_state_r9: assert (!out_valid && (bit_count == '0))
        else $error("reset state wrong");
    end
  end

endmodule

bind escape_word_packer ewp_checker #(
  .WORD_BYTES (WORD_BYTES),
  .CNT_W      (CNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .esc_en    (esc_en),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_word  (out_word),
  .out_ready (out_ready),
  .bit_count (bit_count)
);

// File: tb/escape_word_packer_tb_top.sv
module escape_word_packer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        esc_en = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        flush = 1'b0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_ready = 1'b1;
  logic [31:0] bit_count;

  always #2 clk = ~clk;

  escape_word_packer #(.WORD_BYTES(4), .CNT_W(32)) dut_i (
    .clk(clk), .rst(rst), .esc_en(esc_en), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .flush(flush),
    .out_valid(out_valid), .out_word(out_word), .out_ready(out_ready),
    .bit_count(bit_count)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int stall_lo = 0;
  int stall_hi = 0;
  bit bp_rand = 0;
  bit en_drv = 0;
  bit done = 0;
  int last_wait = 0;
  logic [31:0] got_q[$];

  // reference model state
  int m_mode, m_zc, m_esc, m_pos, m_ov, m_fp;
  logic [31:0] m_acc, m_ow, m_bits;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = 0; m_zc = 0; m_esc = 0; m_pos = 0; m_ov = 0; m_fp = 0;
    m_acc = '0; m_ow = '0; m_bits = '0;
  endtask

  // compare against the model, then advance the model by one clock
  task automatic model_cycle();
    int zce, np;
    bit prdy, escn, xf, fl;
    logic [7:0] b;
    logic [31:0] w;
    zce  = (int'(esc_en) != m_mode) ? 0 : m_zc;
    prdy = !m_ov || out_ready;
    escn = esc_en && in_valid && !m_esc && zce >= 2 &&
           (in_data == 8'h00 || in_data == 8'h01 || in_data == 8'h03);
    xf   = in_valid && prdy;
    b    = escn ? 8'h03 : in_data;
    fl   = flush || m_fp;

    check(in_ready == (prdy && !escn), "R10", "in_ready", in_ready, prdy && !escn);
    check(out_valid == m_ov[0], "R6", "out_valid", out_valid, m_ov);
    if (m_ov != 0) check(out_word == m_ow, "R5", "out_word", out_word, m_ow);
    check(bit_count == m_bits, "R8", "bit_count", bit_count, m_bits);

    if (prdy) begin
      w  = (m_pos == 0) ? 32'h0 : m_acc;
      np = m_pos;
      if (xf) begin
        w[31-8*m_pos -: 8] = b;
        np++;
      end
      if (np == 4 || (fl && np != 0)) begin
        m_ov = 1; m_ow = w; m_pos = 0;
      end else begin
        m_ov = 0; m_pos = np;
      end
      m_acc = w;
      m_fp  = 0;
    end else begin
      m_fp = fl;
    end

    if (xf) begin
      if (escn) begin
        m_esc = 1; m_zc = 0;
      end else begin
        m_esc = 0;
        if (esc_en) m_zc = (in_data == 8'h00) ? ((zce < 2) ? zce + 1 : 2) : 0;
        else        m_zc = zce;
      end
      m_bits = m_bits + 32'd8;
    end else begin
      m_zc = zce;
    end
    m_mode = int'(esc_en);
  endtask

  task automatic tick(input bit v, input logic [7:0] d, input bit f, output bit took);
    @(negedge clk);
    in_valid  = v;
    in_data   = d;
    flush     = f;
    esc_en    = en_drv;
    out_ready = !(cyc >= stall_lo && cyc < stall_hi) && (!bp_rand || ($urandom % 3 != 0));
    #1;
    took = 1'b0;
    if (rst) begin
      model_reset();
    end else begin
      if (out_valid && out_ready) got_q.push_back(out_word);
      took = v && in_ready;
      model_cycle();
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    bit t;
    for (int i = 0; i < n; i++) tick(1'b0, 8'h00, 1'b0, t);
  endtask

  task automatic send(input logic [7:0] b);
    bit t;
    int w;
    t = 1'b0;
    w = 0;
    while (!t) begin
      tick(1'b1, b, 1'b0, t);
      if (!t) w++;
    end
    last_wait = w;
  endtask

  task automatic do_flush();
    bit t;
    tick(1'b0, 8'h00, 1'b1, t);
  endtask

  task automatic fresh(input bit en);
    idle(4);
    got_q.delete();
    en_drv = ~en;
    idle(1);
    en_drv = en;
    idle(1);
  endtask

  task automatic expect_word(input string req, input logic [31:0] exp);
    logic [31:0] g;
    if (got_q.size() == 0) begin
      check(1'b0, req, "missing word", 0, exp);
    end else begin
      g = got_q.pop_front();
      check(g == exp, req, "word", g, exp);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] b0;
    bit t;
    model_reset();
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R9: reset state
    check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    check(bit_count == 32'd0, "R9", "bit_count after reset", bit_count, 0);
    check(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);

    // R4: escaping off, zeros then 01 pass unchanged
    fresh(1'b0);
    b0 = bit_count;
    send(8'h00); send(8'h00); send(8'h00); send(8'h01);
    idle(2);
    expect_word("R4", 32'h00000001);
    check(bit_count - b0 == 32'd32, "R8", "bits disabled", bit_count - b0, 32);

    // R1 / R5 / R10: escape before 01, then flush of a one-byte word (R7)
    fresh(1'b1);
    b0 = bit_count;
    send(8'h00); send(8'h00); send(8'h01);
    check(last_wait == 1, "R10", "stall cycles for escape", last_wait, 1);
    send(8'hAA);
    do_flush();
    idle(3);
    expect_word("R1", 32'h00000301);
    expect_word("R7", 32'hAA000000);
    check(bit_count - b0 == 32'd40, "R8", "bits with escape", bit_count - b0, 40);

    // R2: run of five zeros
    fresh(1'b1);
    b0 = bit_count;
    for (int i = 0; i < 5; i++) send(8'h00);
    do_flush();
    idle(3);
    expect_word("R2", 32'h00000300);
    expect_word("R2", 32'h00030000);
    check(bit_count - b0 == 32'd56, "R8", "bits zero run", bit_count - b0, 56);

    // R1: 02 and 04 pass, 03 is escaped
    fresh(1'b1);
    send(8'h00); send(8'h00); send(8'h02);
    send(8'h00); send(8'h00); send(8'h03);
    send(8'h00); send(8'h00); send(8'h04);
    do_flush();
    idle(3);
    expect_word("R1", 32'h00000200);
    expect_word("R1", 32'h00030300);
    expect_word("R1", 32'h00040000);

    // R3: toggling the mode clears the run
    fresh(1'b1);
    send(8'h00); send(8'h00);
    en_drv = 1'b0; idle(1);
    en_drv = 1'b1;
    send(8'h01);
    check(last_wait == 0, "R3", "no stall after toggle", last_wait, 0);
    do_flush();
    idle(3);
    expect_word("R3", 32'h00000100);

    // R3: same value held over idle cycles keeps the run
    fresh(1'b1);
    send(8'h00); send(8'h00);
    idle(5);
    send(8'h03);
    do_flush();
    idle(3);
    expect_word("R3", 32'h00000303);

    // R7: flush with nothing pending emits nothing
    fresh(1'b0);
    do_flush();
    idle(4);
    check(got_q.size() == 0, "R7", "words after empty flush", got_q.size(), 0);

    // R11: back-pressure
    fresh(1'b0);
    stall_lo = cyc;
    stall_hi = cyc + 15;
    send(8'h11); send(8'h22); send(8'h33); send(8'h44);
    send(8'h55);
    check(last_wait >= 5, "R11", "intake stalled", last_wait, 5);
    send(8'h66); send(8'h77); send(8'h88);
    idle(3);
    expect_word("R11", 32'h11223344);
    expect_word("R11", 32'h55667788);

    // R9: reset mid-word discards position and count
    fresh(1'b0);
    send(8'h01); send(8'h02); send(8'h03);
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    got_q.delete();
    send(8'hA1); send(8'hA2); send(8'hA3); send(8'hA4);
    idle(2);
    expect_word("R9", 32'hA1A2A3A4);
    check(bit_count == 32'd32, "R9", "bit_count restarts", bit_count, 32);

    // R6: random traffic against the model
    fresh(1'b1);
    bp_rand = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      case ($urandom % 6)
        0, 1, 2: send(8'h00);
        3:       send(8'h01);
        4:       send(8'h03);
        default: send(8'($urandom));
      endcase
      if ($urandom % 40 == 0) en_drv = ~en_drv;
      if ($urandom % 25 == 0) tick(1'b0, 8'h00, 1'b1, t);
    end
    bp_rand = 1'b0;
    idle(10);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule